// File: doc/BRIEF.md
# Calibrated Two-Point ADC Code to Millivolt Converter

This block turns one raw 12-bit converter code into a voltage in millivolts. It draws a straight line through two graph points. Each point has a fixed voltage. Its code position comes from a calibration byte that is loaded at setup time. There are two graphs. The wide-range graph is anchored at 4200 mV and 3600 mV, and the narrow-range graph is anchored at 1000 mV and 100 mV. The channel number picks the graph, and a result below zero is forced to zero.

Channel 5 and channel 1 take the graph result as it stands. Every other channel goes through one more step: the narrow-graph result is multiplied and divided by a divider-ratio correction that depends on the scale setting, and this division rounds to nearest. Both divisions run on sequential restoring dividers, so each conversion takes a fixed number of cycles.

Software, or a setup sequencer, loads the calibration words once. After that it issues a start with the code, channel and scale, and reads the result when the done strobe fires.

Top module: `adc_mv_convert`

## Requirements
- R1: After reset `busy`, `done` and `volt_mv` are 0. Until the first load, both graphs behave as if every calibration byte were 128, so each point code is 4 × its nominal code.
- R2: A cycle with `cal_load` high stores the calibration words. Bits 7:0 correct the first point and bits 15:8 correct the second point, each as point = (byte + nominal − 128) × 4. The wide graph's first and second nominal codes are 856 and 733. The narrow graph's are 833 and 80.
- R3: The graph result is (v_first − v_second) × (raw − p_second) / (p_first − p_second) + v_second. It is computed in signed arithmetic, and the quotient truncates toward zero. This also holds when the denominator is negative.
- R4: A negative graph result is replaced by 0.
- R5: Channel 5 returns the wide-graph result unchanged, and channel 1 returns the narrow-graph result unchanged. For both channels the scale input has no effect.
- R6: Every other channel returns (n × den + num/2) / num, where n is the narrow-graph result and the division is integer. num/den is 1/1 at scale 0, 1000/1955 at scale 1, 1000/2586 at scale 2 and 1000/4060 at scale 3.
- R7: `done` is a one-cycle pulse. It rises on the 62nd rising edge after the edge that accepted `start`, and `volt_mv` holds the result from that cycle on. `busy` is high from the cycle after acceptance until the cycle in which `done` rises.
- R8: A `start` while `busy` is high is ignored. The running conversion keeps its result and timing, and no extra `done` follows.
- R9: If the two calibrated points of the chosen graph have the same code, the graph result is v_second.
- R10: A calibration load during a conversion does not change that conversion's result. It applies from the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_load | input | 1 | Store both calibration words this cycle |
| cal_big | input | 16 | Wide-graph calibration: byte for first point [7:0], second point [15:8] |
| cal_small | input | 16 | Narrow-graph calibration, same byte layout |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| raw | input | 12 | Raw converter code |
| chan | input | 5 | Channel number |
| scale | input | 2 | Scale setting for the ratio correction |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| volt_mv | output | 24 | Result in millivolts |

## Verification
The codes are swept across the full 0–4095 range for the wide graph, the narrow graph and three ratio-corrected channels at different scales, under calibration that is not nominal. This shows whether the graph selection, the byte order and the ratio table are all correct. Directed codes check the difference between truncation and flooring just below the second point, and the difference between nearest and downward rounding in the ratio step (1174.955 must give 1175). Other directed codes hit the clamp boundary, a negative denominator and two coincident points. Overlapping starts and calibration loads made during a conversion separate state that is captured at acceptance from state that is read live.

// File: rtl/adc_mv_pkg.sv
package adc_mv_pkg;

  localparam int PT_W     = 16;
  localparam int SCALE_W  = 2;
  localparam int CAL_GAIN = 4;

  // graph anchors (mV) and nominal point codes
  localparam int BIG_V0   = 4200;
  localparam int BIG_V1   = 3600;
  localparam int BIG_N0   = 856;
  localparam int BIG_N1   = 733;
  localparam int SML_V0   = 1000;
  localparam int SML_V1   = 100;
  localparam int SML_N0   = 833;
  localparam int SML_N1   = 80;

  typedef logic signed [PT_W-1:0] pt_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INTERP, ST_RATIO} conv_st_t;

  // calibrated point code: byte recentred on mid, added to nominal, times gain
  function automatic pt_t cal_point(input int cal_byte, input int nominal, input int mid);
    int t;
    t = (cal_byte + nominal - mid) * CAL_GAIN;
    return pt_t'(t);
  endfunction

  // packed ratio: numerator in [31:16], denominator in [15:0]
  function automatic logic [31:0] ratio_word(input logic [SCALE_W-1:0] sc);
    case (sc)
      2'd0:    return {16'd1,    16'd1};
      2'd1:    return {16'd1000, 16'd1955};
      2'd2:    return {16'd1000, 16'd2586};
      default: return {16'd1000, 16'd4060};
    endcase
  endfunction

  function automatic logic [31:0] abs32(input int x);
    return (x < 0) ? 32'(-x) : 32'(x);
  endfunction

endpackage

// File: rtl/adc_cal_points.sv
module adc_cal_points
  import adc_mv_pkg::*;
#(
  parameter int CAL_W = 8,
  parameter int NOM0  = 833,
  parameter int NOM1  = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2*CAL_W-1:0] word,
  output pt_t              pt0,
  output pt_t              pt1
);

  localparam int MID = 1 << (CAL_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt0 <= cal_point(MID, NOM0, MID);
      pt1 <= cal_point(MID, NOM1, MID);
    end else if (load) begin
      pt0 <= cal_point(int'(word[CAL_W-1:0]), NOM0, MID);
      pt1 <= cal_point(int'(word[2*CAL_W-1:CAL_W]), NOM1, MID);
    end
  end

endmodule

// File: rtl/adc_seq_div.sv
module adc_seq_div #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [W:0]       shifted, diff;
  logic             fits;

  // one restoring step: bring in next dividend bit, subtract if it fits
  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = (shifted >= {1'b0, dvs_q});
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(W - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/adc_mv_convert.sv
module adc_mv_convert
  import adc_mv_pkg::*;
#(
  parameter int RAW_W      = 12,
  parameter int CHAN_W     = 5,
  parameter int CAL_W      = 8,
  parameter int INTERP_W   = 24,
  parameter int RATIO_W    = 36,
  parameter int BIG_CHAN   = 5,
  parameter int SMALL_CHAN = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_load,
  input  logic [2*CAL_W-1:0]   cal_big,
  input  logic [2*CAL_W-1:0]   cal_small,
  input  logic                 start,
  input  logic [RAW_W-1:0]     raw,
  input  logic [CHAN_W-1:0]    chan,
  input  logic [SCALE_W-1:0]   scale,
  output logic                 busy,
  output logic                 done,
  output logic [INTERP_W-1:0]  volt_mv
);

  localparam int OUT_W   = INTERP_W;
  localparam int LATENCY = INTERP_W + RATIO_W + 2;

  conv_st_t state;

  // calibrated graph points, one store per graph
  pt_t big0, big1, sml0, sml1;

  adc_cal_points #(.CAL_W(CAL_W), .NOM0(BIG_N0), .NOM1(BIG_N1)) u_cal_big (
    .clk(clk), .rst_n(rst_n), .load(cal_load), .word(cal_big),
    .pt0(big0), .pt1(big1)
  );

  adc_cal_points #(.CAL_W(CAL_W), .NOM0(SML_N0), .NOM1(SML_N1)) u_cal_small (
    .clk(clk), .rst_n(rst_n), .load(cal_load), .word(cal_small),
    .pt0(sml0), .pt1(sml1)
  );

  // ---------------- operand preparation at acceptance ----------------
  logic accept;
  logic use_big;
  pt_t  pa0, pa1;
  int   span_v, v1_in, code_off, prod, den;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    use_big  = (chan == CHAN_W'(BIG_CHAN));
    pa0      = use_big ? big0 : sml0;
    pa1      = use_big ? big1 : sml1;
    span_v   = use_big ? (BIG_V0 - BIG_V1) : (SML_V0 - SML_V1);
    v1_in    = use_big ? BIG_V1 : SML_V1;
    code_off = int'(raw) - int'(pa1);
    prod     = span_v * code_off;
    den      = int'(pa0) - int'(pa1);
  end

  logic [INTERP_W-1:0] div1_a, div1_b, div1_q;
  logic                div1_done;

  assign div1_a = INTERP_W'(abs32(prod));
  assign div1_b = INTERP_W'(abs32(den));

  adc_seq_div #(.W(INTERP_W)) u_div_interp (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .dividend(div1_a), .divisor(div1_b),
    .quotient(div1_q), .done(div1_done)
  );

  // context captured when a conversion is accepted
  logic [CHAN_W-1:0]  chan_q;
  logic [SCALE_W-1:0] scale_q;
  logic               neg_q, zero_q;
  int                 v1_q;

  // ---------------- graph result: sign, offset, clamp ----------------
  int                 q_signed, interp_sum;
  logic [OUT_W-1:0]   interp_mv;

  always_comb begin
    if (zero_q)     q_signed = 0;
    else if (neg_q) q_signed = -int'(div1_q);
    else            q_signed = int'(div1_q);
    interp_sum = q_signed + v1_q;
    interp_mv  = (interp_sum < 0) ? '0 : OUT_W'(interp_sum);
  end

  // ---------------- ratio correction with nearest rounding ----------------
  logic               conv_direct;
  logic [31:0]        rword;
  logic [15:0]        rnum, rden;
  logic [RATIO_W-1:0] div2_a, div2_b, div2_q;
  logic               div2_go, div2_done;

  assign conv_direct = (chan_q == CHAN_W'(BIG_CHAN)) || (chan_q == CHAN_W'(SMALL_CHAN));
  assign rword       = ratio_word(conv_direct ? SCALE_W'(0) : scale_q);
  assign rnum        = rword[31:16];
  assign rden        = rword[15:0];
  assign div2_a      = RATIO_W'(interp_mv) * RATIO_W'(rden) + RATIO_W'(rnum >> 1);
  assign div2_b      = RATIO_W'(rnum);
  assign div2_go     = (state == ST_INTERP) && div1_done;

  adc_seq_div #(.W(RATIO_W)) u_div_ratio (
    .clk(clk), .rst_n(rst_n), .start(div2_go),
    .dividend(div2_a), .divisor(div2_b),
    .quotient(div2_q), .done(div2_done)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      volt_mv <= '0;
      chan_q  <= '0;
      scale_q <= '0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      v1_q    <= 0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          chan_q  <= chan;
          scale_q <= scale;
          neg_q   <= prod[31] ^ den[31];
          zero_q  <= (den == 0);
          v1_q    <= v1_in;
          state   <= ST_INTERP;
        end
        ST_INTERP: if (div1_done) state <= ST_RATIO;
        ST_RATIO: if (div2_done) begin
          // upper quotient bits are zero for any reachable operand; saturate defensively
          volt_mv <= (|div2_q[RATIO_W-1:OUT_W]) ? '1 : div2_q[OUT_W-1:0];
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_mv_convert_chk.sv
module adc_mv_convert_chk #(
  parameter int LAT   = 62,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             conv_direct,
  input logic [1:0]       scale_q,
  input logic [OUT_W-1:0] interp_mv,
  input logic [OUT_W-1:0] volt_mv
);

  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy)           lat_cnt <= lat_cnt + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == 16'(LAT));

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_accept_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r5_direct_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (done && conv_direct) |-> volt_mv == interp_mv);

  a_r6_unity_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (done && scale_q == 2'd0) |-> volt_mv == interp_mv);

endmodule

bind adc_mv_convert adc_mv_convert_chk #(.LAT(LATENCY), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .conv_direct(conv_direct), .scale_q(scale_q),
  .interp_mv(interp_mv), .volt_mv(volt_mv)
);

// File: tb/test_adc_mv_convert.sv
`timescale 1ns/1ps
module test_adc_mv_convert;

  localparam int LAT = 62;

  logic        clk = 1'b0, rst_n = 1'b0, cal_load = 1'b0, start = 1'b0;
  logic [15:0] cal_big = '0, cal_small = '0;
  logic [11:0] raw = '0;
  logic [4:0]  chan = '0;
  logic [1:0]  scale = '0;
  logic        busy, done;
  logic [23:0] volt_mv;

  int          n_chk = 0, n_fail = 0;
  logic [15:0] ref_big = 16'h8080, ref_small = 16'h8080;

  always #2 clk = ~clk;

  adc_mv_convert i_adc_mv_convert (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_big(cal_big),
    .cal_small(cal_small), .start(start), .raw(raw), .chan(chan),
    .scale(scale), .busy(busy), .done(done), .volt_mv(volt_mv)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------- reference model, written from the requirements ----------
  function automatic longint ref_pt(input int b, input int nom);
    return longint'((b + nom - 128) * 4);
  endfunction

  function automatic longint ref_line(input longint v0, input longint v1,
                                      input longint a0, input longint a1, input longint r);
    longint t;
    if (a0 == a1) t = v1;
    else          t = (v0 - v1) * (r - a1) / (a0 - a1) + v1;
    return (t < 0) ? 0 : t;
  endfunction

  function automatic longint ref_volt(input int r, input int ch, input int sc);
    longint wide, narrow, num, den;
    wide   = ref_line(4200, 3600, ref_pt(int'(ref_big[7:0]), 856),
                      ref_pt(int'(ref_big[15:8]), 733), r);
    narrow = ref_line(1000, 100, ref_pt(int'(ref_small[7:0]), 833),
                      ref_pt(int'(ref_small[15:8]), 80), r);
    if (ch == 5) return wide;
    if (ch == 1) return narrow;
    case (sc)
      0:       begin num = 1;    den = 1;    end
      1:       begin num = 1000; den = 1955; end
      2:       begin num = 1000; den = 2586; end
      default: begin num = 1000; den = 4060; end
    endcase
    return (narrow * den + num / 2) / num;
  endfunction

  // ---------- drivers ----------
  task automatic load_cal(input logic [15:0] b, input logic [15:0] s);
    @(negedge clk);
    cal_big = b; cal_small = s; cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    ref_big = b; ref_small = s;
  endtask

  task automatic pulse_start(input int r, input int ch, input int sc);
    @(negedge clk);
    raw = 12'(r); chan = 5'(ch); scale = 2'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < LAT + 40) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_conv(input int r, input int ch, input int sc, output longint got);
    int k;
    pulse_start(r, ch, sc);
    wait_done(k);
    got = longint'(volt_mv);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    longint g;
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 done after reset", longint'(done), 0);
    chk("R1 volt after reset", longint'(volt_mv), 0);
    run_conv(2000, 1, 0, g);
    chk("R1 default narrow cal", g, 601);
    run_conv(2000, 5, 0, g);
    chk("R1 default wide cal", g, 2464);
  endtask

  task automatic t_timing_r7();
    int k;
    pulse_start(1234, 9, 1);
    chk("R7 busy after accept", longint'(busy), 1);
    wait_done(k);
    chk("R7 latency", longint'(k), LAT);
    chk("R7 busy low at done", longint'(busy), 0);
    chk("R7 result", longint'(volt_mv), ref_volt(1234, 9, 1));
    @(negedge clk);
    chk("R7 done one cycle", longint'(done), 0);
    chk("R7 result held", longint'(volt_mv), ref_volt(1234, 9, 1));
  endtask

  task automatic t_interp_r3();
    longint g;
    run_conv(318, 1, 0, g);
    chk("R3 truncation toward zero", g, 100);
    load_cal(16'hFF00, 16'h8080);
    run_conv(4095, 5, 0, g);
    chk("R3 negative denominator high code", g, 2856);
    run_conv(0, 5, 0, g);
    chk("R3 negative denominator low code", g, 7509);
  endtask

  task automatic t_clamp_r4();
    longint g;
    load_cal(16'h8080, 16'hFF00);
    run_conv(0, 1, 0, g);
    chk("R4 clamp at code 0", g, 0);
    run_conv(500, 1, 0, g);
    chk("R4 clamp at code 500", g, 0);
    run_conv(700, 1, 0, g);
    chk("R4 just above clamp", g, 43);
    run_conv(0, 7, 3, g);
    chk("R4 clamp before ratio", g, 0);
  endtask

  task automatic t_cal_r2();
    longint g;
    load_cal(16'h8080, 16'h4010);
    run_conv(2500, 1, 0, g);
    chk("R2 byte order 0x4010", g, 877);
    load_cal(16'h8080, 16'h1040);
    run_conv(2500, 1, 0, g);
    chk("R2 byte order 0x1040", g, 838);
  endtask

  task automatic t_ratio_r6();
    longint g;
    load_cal(16'h8080, 16'h8080);
    run_conv(2000, 2, 0, g);
    chk("R6 scale 0", g, 601);
    run_conv(2000, 2, 1, g);
    chk("R6 scale 1 rounds up", g, 1175);
    run_conv(2000, 2, 2, g);
    chk("R6 scale 2", g, 1554);
    run_conv(2000, 2, 3, g);
    chk("R6 scale 3", g, 2440);
  endtask

  task automatic t_select_r5();
    longint g;
    run_conv(2000, 5, 3, g);
    chk("R5 wide channel ignores scale", g, 2464);
    run_conv(2000, 1, 3, g);
    chk("R5 narrow channel ignores scale", g, 601);
    run_conv(2000, 6, 0, g);
    chk("R5 other channel uses narrow graph", g, 601);
  endtask

  task automatic t_equal_r9();
    longint g;
    load_cal(16'h8B10, 16'h8080);
    run_conv(100, 5, 0, g);
    chk("R9 coincident points low", g, 3600);
    run_conv(4000, 5, 0, g);
    chk("R9 coincident points high", g, 3600);
    load_cal(16'h8080, 16'h8080);
  endtask

  task automatic t_busy_r8();
    int k, extra;
    pulse_start(2000, 1, 0);
    k = 0;
    while (!done && k < LAT + 40) begin
      @(negedge clk);
      k++;
      if (k == 9) begin raw = 12'd100; chan = 5'd5; start = 1'b1; end
      if (k == 10) start = 1'b0;
    end
    chk("R8 latency unchanged", longint'(k), LAT);
    chk("R8 result unchanged", longint'(volt_mv), 601);
    extra = 0;
    repeat (LAT + 10) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8 no extra done", longint'(extra), 0);
  endtask

  task automatic t_inflight_r10();
    int k;
    longint g;
    pulse_start(2000, 1, 0);
    k = 0;
    while (!done && k < LAT + 40) begin
      @(negedge clk);
      k++;
      if (k == 5) begin cal_small = 16'hFF00; cal_load = 1'b1; end
      if (k == 6) cal_load = 1'b0;
    end
    chk("R10 in-flight result uses old cal", longint'(volt_mv), 601);
    ref_small = 16'hFF00;
    run_conv(2000, 1, 0, g);
    chk("R10 next conversion uses new cal", g, 629);
  endtask

  task automatic t_sweep();
    longint g;
    int chs[6] = '{1, 5, 7, 12, 20, 3};
    int scs[6] = '{0, 0, 1, 2, 3, 0};
    load_cal(16'h7390, 16'h6A95);
    for (int c = 0; c < 6; c++) begin
      for (int r = 0; r <= 4095; r = (r == 4070) ? 4095 : r + 37) begin
        run_conv(r, chs[c], scs[c], g);
        chk($sformatf("R3 R6 sweep ch%0d sc%0d code %0d", chs[c], scs[c], r),
            g, ref_volt(r, chs[c], scs[c]));
        if (r == 4095) break;
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing_r7();
    t_interp_r3();
    t_clamp_r4();
    t_cal_r2();
    t_ratio_r6();
    t_select_r5();
    t_equal_r9();
    t_busy_r8();
    t_inflight_r10();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule